// File: doc/BRIEF.md
# Timer Control Register Bank with Atomic Bit Aliases

This block is the software-visible register bank of a 16-bit timer peripheral. It holds the timer's control word and period value, forwards writes of the count value to the timer core, and returns read data over a simple single-cycle bus made of an address, a write enable, write data and combinational read data.

Each register answers at four word addresses. The base address replaces the whole value. The three alias addresses clear, set or invert only the bits given as 1 in the write data. Software can therefore start or stop the timer, or flip a single option, without a read-modify-write sequence.

Reads of the control word hide bits that do not apply to the selected mode. Unimplemented bit positions never hold a 1.

Top module: `tmr_reg_bank`

## Requirements
- R1: A write to a register's base address (offset +0) replaces every writable bit with the write data. For example, 0x0030 written to the control base leaves the control word at 0x0030.
- R2: A write to the clear alias (offset +4) clears exactly the bits given as 1 in the write data and leaves the other bits unchanged.
- R3: A write to the set alias (offset +8) sets exactly the bits given as 1. For example, 0x8000 written there sets only bit 15.
- R4: A write to the invert alias (offset +12) toggles exactly the bits given as 1.
- R5: Control bits 10:8, 6, 3 and 0 are unimplemented. They never hold a 1 and always read 0. Write data on those bits is discarded.
- R6: Control bit 1 selects the clock source. While it is 1, the gate-enable bit (bit 7) reads 0. While it is 0, the sync bit (bit 2) reads 0. The stored values of both bits are kept and are visible on ctrl_o.
- R7: Control bit 11 is the write-in-progress flag and is read-only. It reads as wip_i only in asynchronous mode (bit 1 = 1 and bit 2 = 0), and reads 0 otherwise. No alias write can store it.
- R8: The period register sits at base 0x20 and supports all four aliases. prd_o takes the new value on the clock edge of the write, and prd_wr_o pulses for that one cycle. It resets to 0xFFFF.
- R9: The count register sits at base 0x10. Its aliases operate on cnt_i. On the edge of the write, cnt_wdata_o takes the result and cnt_wr_o pulses for one cycle. Reads return cnt_i.
- R10: The control register sits at base 0x00, and all four alias addresses of a register read that register's value. Unaligned addresses and register indices above 2 read 0, and writes to them change nothing.
- R11: After reset the control word is 0x0000, the period is 0xFFFF and neither write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| ctrl_o | output | 16 | Stored control word toward the timer core |
| prd_o | output | 16 | Period value toward the timer core |
| prd_wr_o | output | 1 | One-cycle pulse after a period write |
| cnt_i | input | 16 | Current count from the timer core |
| cnt_wdata_o | output | 16 | New count value for the core |
| cnt_wr_o | output | 1 | One-cycle pulse requesting a count load |
| wip_i | input | 1 | Asynchronous write in progress flag from the core |

## Verification
The bench checks alias writes whose data overlaps bits that are already set and bits that are already clear. A design that decoded the offsets in the wrong order, or that applied an alias as a plain write, would leave the wrong word behind.

It also writes all ones to each control alias. This catches storage of the unimplemented bits or the read-only flag: such a design would show a stray 1 on ctrl_o or on a read.

Reads are taken under each clock-source and sync combination while wip_i is toggled. This exposes a mask tied to the wrong mode bit.

Count aliases are applied while cnt_i is changing. A bank that operated on a stale copy of the count would send a wrong load value. Writes to unaligned and out-of-range addresses would show up as unexpected strobes or changed registers.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;
  localparam int REG_W   = 16;
  localparam int N_REGS  = 3;
  localparam int REG_CTRL = 0;
  localparam int REG_CNT  = 1;
  localparam int REG_PRD  = 2;

  localparam int B_EN    = 15;
  localparam int B_FRZ   = 14;
  localparam int B_SIDL  = 13;
  localparam int B_WDIS  = 12;
  localparam int B_WIP   = 11;
  localparam int B_GATE  = 7;
  localparam int B_PS_HI = 5;
  localparam int B_PS_LO = 4;
  localparam int B_SYNC  = 2;
  localparam int B_SRC   = 1;

  // writable control bits: everything implemented except the read-only flag
  localparam logic [REG_W-1:0] CTRL_WMASK = REG_W'(
      (1 << B_EN) | (1 << B_FRZ) | (1 << B_SIDL) | (1 << B_WDIS) |
      (1 << B_GATE) | (1 << B_PS_HI) | (1 << B_PS_LO) | (1 << B_SYNC) | (1 << B_SRC));
  localparam logic [REG_W-1:0] ALL_ONES = '1;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_CLR = 2'd1,
    OP_SET = 2'd2,
    OP_INV = 2'd3
  } alias_op_e;
endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
  import tmr_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = N_REGS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o,
  output alias_op_e         op_o
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr_i[ADDR_W-1:4];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign op_o    = alias_op_e'(addr_i[3:2]);

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel_o[i] = aligned && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/tmr_alias_reg.sv
module tmr_alias_reg
  import tmr_regs_pkg::*;
#(
  parameter int              W     = REG_W,
  parameter logic [W-1:0]    WMASK = '1,
  parameter logic [W-1:0]    RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] q_o,
  output logic         wr_o
);
  logic [W-1:0] res, nxt;

  always_comb begin
    unique case (op_i)
      OP_WR:   res = wdata_i;
      OP_CLR:  res = cur_i & ~wdata_i;
      OP_SET:  res = cur_i | wdata_i;
      default: res = cur_i ^ wdata_i;
    endcase
    nxt = (res & WMASK) | (cur_i & ~WMASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o  <= RST;
      wr_o <= 1'b0;
    end else begin
      wr_o <= hit_i;
      if (hit_i) q_o <= nxt;
    end
  end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
  import tmr_regs_pkg::*;
(
  input  logic [N_REGS-1:0] sel_i,
  input  logic [REG_W-1:0]  ctrl_q_i,
  input  logic [REG_W-1:0]  cnt_i,
  input  logic [REG_W-1:0]  prd_q_i,
  input  logic              wip_i,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] ctrl_view;
  logic             src, sync_on;

  assign src     = ctrl_q_i[B_SRC];
  assign sync_on = ctrl_q_i[B_SYNC];

  always_comb begin
    ctrl_view = ctrl_q_i & CTRL_WMASK;
    if (src)  ctrl_view[B_GATE] = 1'b0;
    else      ctrl_view[B_SYNC] = 1'b0;
    ctrl_view[B_WIP] = wip_i && src && !sync_on;
  end

  assign rdata_o = ({REG_W{sel_i[REG_CTRL]}} & ctrl_view) |
                   ({REG_W{sel_i[REG_CNT]}}  & cnt_i)     |
                   ({REG_W{sel_i[REG_PRD]}}  & prd_q_i);
endmodule

// File: rtl/tmr_reg_bank.sv
module tmr_reg_bank
  import tmr_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  prd_o,
  output logic              prd_wr_o,
  input  logic [REG_W-1:0]  cnt_i,
  output logic [REG_W-1:0]  cnt_wdata_o,
  output logic              cnt_wr_o,
  input  logic              wip_i
);
  logic [N_REGS-1:0] sel;
  alias_op_e         op;
  logic [REG_W-1:0]  q   [N_REGS];
  logic              wr  [N_REGS];

  tmr_addr_decode #(.ADDR_W(ADDR_W), .NREG(N_REGS)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .op_o   (op)
  );

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    localparam logic [REG_W-1:0] WM  = (i == REG_CTRL) ? CTRL_WMASK : ALL_ONES;
    localparam logic [REG_W-1:0] RV  = (i == REG_PRD)  ? ALL_ONES   : '0;
    logic [REG_W-1:0] cur;
    if (i == REG_CNT) begin : g_live
      assign cur = cnt_i;          // aliases act on the core's live count
    end else begin : g_own
      assign cur = q[i];
    end
    tmr_alias_reg #(.W(REG_W), .WMASK(WM), .RST(RV)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (we_i && sel[i]),
      .op_i    (op),
      .wdata_i (wdata_i),
      .cur_i   (cur),
      .q_o     (q[i]),
      .wr_o    (wr[i])
    );
  end

  tmr_read_mux u_rd (
    .sel_i    (sel),
    .ctrl_q_i (q[REG_CTRL]),
    .cnt_i    (cnt_i),
    .prd_q_i  (q[REG_PRD]),
    .wip_i    (wip_i),
    .rdata_o  (rdata_o)
  );

  assign ctrl_o      = q[REG_CTRL];
  assign prd_o       = q[REG_PRD];
  assign prd_wr_o    = wr[REG_PRD];
  assign cnt_wdata_o = q[REG_CNT];
  assign cnt_wr_o    = wr[REG_CNT];
endmodule

// File: rtl/tmr_reg_bank_chk.sv
module tmr_reg_bank_chk
  import tmr_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [REG_W-1:0]  ctrl_o,
  input logic [REG_W-1:0]  prd_o,
  input logic              prd_wr_o,
  input logic [REG_W-1:0]  cnt_i,
  input logic [REG_W-1:0]  cnt_wdata_o,
  input logic              cnt_wr_o,
  input logic              wip_i
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_PRD  = ADDR_W'(8'h20);

  logic cnt_hit, prd_hit;
  assign cnt_hit = we_i && (addr_i[ADDR_W-1:4] == A_CNT[ADDR_W-1:4]) && (addr_i[1:0] == 2'b00);
  assign prd_hit = we_i && (addr_i[ADDR_W-1:4] == A_PRD[ADDR_W-1:4]) && (addr_i[1:0] == 2'b00);

  a_r1_base_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL) |=> ctrl_o == ($past(wdata_i) & CTRL_WMASK));
  a_r2_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == (A_CTRL + ADDR_W'(4))) |=> ctrl_o == ($past(ctrl_o) & ~$past(wdata_i) & CTRL_WMASK));
  a_r3_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == (A_CTRL + ADDR_W'(8))) |=> ctrl_o == (($past(ctrl_o) | $past(wdata_i)) & CTRL_WMASK));
  a_r4_inv_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == (A_CTRL + ADDR_W'(12))) |=> ctrl_o == (($past(ctrl_o) ^ $past(wdata_i)) & CTRL_WMASK));
  a_r5_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o & ~CTRL_WMASK) == '0);
  a_r6_gate_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL && ctrl_o[B_SRC]) |-> !rdata_o[B_GATE]);
  a_r6_sync_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL && !ctrl_o[B_SRC]) |-> !rdata_o[B_SYNC]);
  a_r7_wip_sync_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL && !(ctrl_o[B_SRC] && !ctrl_o[B_SYNC])) |-> !rdata_o[B_WIP]);
  a_r8_prd_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_hit |=> prd_wr_o);
  a_r8_prd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prd_hit |=> (!prd_wr_o && $stable(prd_o)));
  a_r9_cnt_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_hit |=> cnt_wr_o);
  a_r9_cnt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_hit |=> !cnt_wr_o);
  a_r9_cnt_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CNT) |-> rdata_o == cnt_i);
endmodule

bind tmr_reg_bank tmr_reg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tmr_reg_bank_test.sv
`timescale 1ns/1ps
module tmr_reg_bank_test;
  localparam int AW = 8;
  localparam logic [15:0] WM = 16'hF0B6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o, ctrl_o, prd_o, cnt_wdata_o;
  logic        prd_wr_o, cnt_wr_o;
  logic [15:0] cnt_i = 16'h1234;
  logic        wip_i = 1'b0;

  int total = 0;
  int bad = 0;
  logic [15:0] m_ctrl, m_prd;

  always #2 clk_i = ~clk_i;

  tmr_reg_bank #(.ADDR_W(AW)) uut (.*);

  function automatic logic [15:0] f_apply(int op, logic [15:0] cur, logic [15:0] d);
    case (op)
      0: return d;
      1: return cur & ~d;
      2: return cur | d;
      default: return cur ^ d;
    endcase
  endfunction

  function automatic logic [15:0] f_ctrl_view(logic [15:0] c, logic w);
    logic [15:0] v;
    v = c & WM;
    if (c[1]) v[7] = 1'b0; else v[2] = 1'b0;
    v[11] = w && c[1] && !c[2];
    return v;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reg: 0 ctrl, 1 cnt, 2 prd ; op: alias 0..3 ; valid=0 builds a dead address
  task automatic do_write(int reg_i, int op, logic [15:0] d, bit valid);
    logic [AW-1:0] a;
    logic [15:0] cnt_now;
    a = AW'((reg_i << 4) | (op << 2));
    if (!valid) a = a | AW'(($urandom % 3) + 1);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b1; wdata_i = d; cnt_now = cnt_i;
    @(negedge clk_i);
    we_i = 1'b0;
    if (valid && reg_i == 0) m_ctrl = f_apply(op, m_ctrl, d) & WM;
    if (valid && reg_i == 2) m_prd = f_apply(op, m_prd, d);
    chk("R1-ctrl R2 R3 R4 R5", ctrl_o, m_ctrl);
    chk("R8 prd", prd_o, m_prd);
    chk("R8 prd_wr", {15'd0, prd_wr_o}, {15'd0, valid && reg_i == 2});
    chk("R9 cnt_wr R10", {15'd0, cnt_wr_o}, {15'd0, valid && reg_i == 1});
    if (valid && reg_i == 1) chk("R9 cnt_wdata", cnt_wdata_o, f_apply(op, cnt_now, d));
  endtask

  task automatic do_read(int reg_i, int op);
    logic [15:0] e;
    @(negedge clk_i);
    addr_i = AW'((reg_i << 4) | (op << 2));
    #1;
    case (reg_i)
      0: e = f_ctrl_view(m_ctrl, wip_i);
      1: e = cnt_i;
      2: e = m_prd;
      default: e = 16'h0;
    endcase
    chk("R6 R7 R10 read", rdata_o, e);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    m_ctrl = 16'h0; m_prd = 16'hFFFF;
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk("R11 ctrl", ctrl_o, 16'h0);
    chk("R11 prd", prd_o, 16'hFFFF);
    chk("R11 strobes", {14'd0, prd_wr_o, cnt_wr_o}, 16'h0);
    do_read(0, 0);

    // R1 and R3 examples
    do_write(0, 0, 16'h0030, 1'b1);
    chk("R1 example", ctrl_o, 16'h0030);
    do_write(0, 2, 16'h8000, 1'b1);
    chk("R3 example", ctrl_o, 16'h8030);
    do_write(0, 1, 16'h8010, 1'b1);
    chk("R2 clear", ctrl_o, 16'h0020);
    do_write(0, 3, 16'h00A2, 1'b1);
    chk("R4 invert", ctrl_o, 16'h0082);
    // R5 and R7: all ones on every alias
    do_write(0, 0, 16'hFFFF, 1'b1);
    chk("R5 R7 all ones", ctrl_o, 16'hF0B6);
    do_write(0, 3, 16'hFFFF, 1'b1);
    chk("R5 invert all", ctrl_o, 16'h0000);
    do_write(0, 2, 16'hFFFF, 1'b1);
    chk("R5 set all", ctrl_o, 16'hF0B6);
    // R6 / R7 masking across modes
    for (int m = 0; m < 4; m++) begin
      do_write(0, 0, 16'h0084 | 16'(((m & 1) << 1) | ((m >> 1) << 2)), 1'b1);
      wip_i = 1'b1; do_read(0, m);
      wip_i = 1'b0; do_read(0, 0);
    end
    wip_i = 1'b1;
    do_write(0, 0, 16'h0002, 1'b1);
    @(negedge clk_i); addr_i = 8'h00; #1;
    chk("R7 async wip", rdata_o, 16'h0802);
    chk("R6 R7 ctrl_o keeps stored", ctrl_o, 16'h0002);
    wip_i = 1'b0;
    // R8 / R9 directed
    do_write(2, 0, 16'h00FF, 1'b1);
    do_write(2, 3, 16'h0F0F, 1'b1);
    chk("R8 prd inv", prd_o, 16'h0FF0);
    cnt_i = 16'h00F0;
    do_write(1, 2, 16'h000F, 1'b1);
    chk("R9 cnt set", cnt_wdata_o, 16'h00FF);
    // R10 dead addresses
    do_write(0, 0, 16'hFFFF, 1'b0);
    do_write(3, 0, 16'hFFFF, 1'b1);
    @(negedge clk_i); addr_i = 8'h31; #1;
    chk("R10 dead read", rdata_o, 16'h0);

    for (int n = 0; n < 600; n++) begin
      int r, o;
      cnt_i = 16'($urandom);
      wip_i = 1'($urandom);
      r = $urandom % 3;
      o = $urandom % 4;
      if ($urandom % 2) do_write(r, o, 16'($urandom), ($urandom % 8) != 0);
      else do_read(r, $urandom % 4);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule